// File: doc/BRIEF.md
# USB Endpoint Interrupt Aggregator

This block keeps the interrupt status of every endpoint of a USB device controller and folds it into a three-level interrupt tree. Each endpoint has a 16-bit status word. Single-cycle event strobes from the endpoint logic set bits in that word, and the bits stay set until software clears them. The transmit-FIFO-empty bit is the one exception: it is not a latched event. It follows the fill level of the endpoint FIFO against a threshold that software selects.

Every word is masked by a per-direction enable mask. The masked word is reduced to one bit per endpoint in an all-endpoints summary, and the two halves of that summary become the global IN and OUT endpoint interrupt lines. The summary and the global bits are computed from the stored flags and keep no state of their own. Clearing the last enabled flag therefore drops the whole chain at once.

The packet-dropped bit is reported in the status word only and never raises an interrupt. Three event types are qualified by the DMA mode inputs. The register port reads with one cycle of latency and clears status bits by write-one-to-clear.

Top module: `usbep_irq_agg`

## Requirements
- R1: Reset state. After reset every status bit reads 0, except bit 7 of each IN word, which reads 1 while the FIFO fill is 0. Both enable masks read 0, and the summary and both interrupt lines are 0.
- R2: Sticky status. IN word n is at address 0x10+n and OUT word n is at 0x20+n. A one-cycle event strobe sets its bit, and the bit holds until a write of 1 to that bit position. Writing 0 to a bit leaves it unchanged.
- R3: Set beats clear. When an event strobe and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R4: Reserved bits of IN words are bit 10 and bits 15 to 31. They always read 0, and strobes or writes to them have no effect.
- R5: IN bit 7 (FIFO empty) is a level flag. It reflects the fill level one cycle after the fill level changes.
  - With the full-only input at 0, it is 1 when fill <= FIFO_DEPTH/2.
  - With the full-only input at 1, it is 1 only when fill == 0.
  - Strobes and writes to bit 7 do not change it.
- R6: Bit 11 (packet dropped) has no enable bit. Enable-mask bit 11 always reads 0, and a set bit 11 never reaches the summary or an interrupt line. The IN enable mask is at 0x02 and the OUT enable mask is at 0x03.
- R7: The summary at 0x00 is built per endpoint. Bit n is set when IN word n ANDed with the IN mask is nonzero. Bit 16+n is set when OUT word n ANDed with the OUT mask is nonzero. Changing a mask changes the summary without touching the status words.
- R8: in_ep_irq is the OR of summary bits 15:0, and out_ep_irq is the OR of bits 31:16. Both are also readable at 0x01 as bit 0 (IN) and bit 1 (OUT). Clearing the last enabled flag drops them in the cycle after the write.
- R9: Bit 2 (bus error) is set by its strobe only while dma_en is 1.
- R10: Bit 3 (timeout) ignores its strobe while sg_en is 1. Bit 9 (buffer not available) ignores its strobe while sg_en is 0.
- R11: A pulse on in_cnak[n] clears bit 6 (NAK effective) of IN word n. If bit 6 is strobed in the same cycle, the strobe wins.
- R12: Read data appears on reg_rdata in the cycle after reg_rd and is 0 in any cycle after no read. Unmapped addresses read 0, including words of endpoints that are not implemented.
- R13: OUT words implement only bits 0, 1, 2, 9, 11, 12, 13 and 14. All other OUT bits read 0 whatever is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| in_evt | input | 16*NUM_IN_EP | Event strobes, 16 per IN endpoint |
| out_evt | input | 16*NUM_OUT_EP | Event strobes, 16 per OUT endpoint |
| in_cnak | input | NUM_IN_EP | Clear-NAK pulse per IN endpoint |
| dma_en | input | 1 | Internal DMA mode enabled |
| sg_en | input | 1 | Scatter/gather DMA mode enabled |
| txe_full_only | input | 1 | 1: FIFO empty means fully empty; 0: half empty |
| in_fifo_fill | input | FILL_W*NUM_IN_EP | FIFO fill level per IN endpoint |
| in_ep_irq | output | 1 | Global IN endpoint interrupt |
| out_ep_irq | output | 1 | Global OUT endpoint interrupt |

## Verification
A strobe or clear applied before clock edge k changes the status word at edge k. The summary and both interrupt lines follow in that same cycle, because no register lies beyond the flags. A fill-level change also reaches bit 7 at the next edge. Read data is registered, so a word is valid one edge after reg_rd. The bench drives every input on the falling edge and samples the interrupt lines on the following falling edge. It takes read data on the falling edge after the read cycle, so each result is picked up exactly one edge after its cause.

// File: rtl/usbep_pkg.sv
package usbep_pkg;
  localparam int EPW    = 16;   // status word width per endpoint
  localparam int REG_DW = 32;
  localparam int REG_AW = 6;

  // bit positions inside an endpoint status word
  localparam int B_XFER    = 0;
  localparam int B_DISABLE = 1;
  localparam int B_BUSERR  = 2;
  localparam int B_TIMEOUT = 3;
  localparam int B_TKNEMPT = 4;
  localparam int B_TKNMIS  = 5;
  localparam int B_NAKEFF  = 6;
  localparam int B_TXFE    = 7;
  localparam int B_UNDRN   = 8;
  localparam int B_BNA     = 9;
  localparam int B_DROP    = 11;
  localparam int B_BABBLE  = 12;
  localparam int B_NAK     = 13;
  localparam int B_NYET    = 14;

  localparam logic [EPW-1:0] IN_VALID  = 16'h7BFF;
  localparam logic [EPW-1:0] OUT_VALID = 16'h7A07;
  localparam logic [EPW-1:0] NO_MASK   = 16'h0001 << B_DROP;

  // register map: addr[5:4] selects region, addr[3:0] selects entry
  localparam logic [1:0] RGN_CTRL = 2'd0;
  localparam logic [1:0] RGN_IN   = 2'd1;
  localparam logic [1:0] RGN_OUT  = 2'd2;
  localparam logic [3:0] A_SUMMARY = 4'd0;
  localparam logic [3:0] A_GLOBAL  = 4'd1;
  localparam logic [3:0] A_INMSK   = 4'd2;
  localparam logic [3:0] A_OUTMSK  = 4'd3;
endpackage

// File: rtl/usbep_flag_bank.sv
module usbep_flag_bank
  import usbep_pkg::*;
#(
  parameter logic [15:0] VALID      = 16'h7BFF,
  parameter bit          HAS_FIFO   = 1'b1,
  parameter int          FIFO_DEPTH = 16,
  parameter int          FILL_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EPW-1:0]    evt,
  input  logic [EPW-1:0]    clr,
  input  logic              cnak,
  input  logic              dma_en,
  input  logic              sg_en,
  input  logic              full_only,
  input  logic [FILL_W-1:0] fill,
  output logic [EPW-1:0]    flags
);
  localparam logic [EPW-1:0]    STICKY = VALID & ~(16'h0001 << B_TXFE);
  localparam logic [FILL_W-1:0] HALF   = FILL_W'(FIFO_DEPTH / 2);

  logic [EPW-1:0] gate, set_v, clr_v, sticky_q;
  logic           empty_q, empty_cond;

  always_comb begin
    gate            = '0;
    gate[B_BUSERR]  = !dma_en;
    gate[B_TIMEOUT] = sg_en;
    gate[B_BNA]     = !sg_en;
    set_v           = evt & STICKY & ~gate;
    clr_v           = clr | (EPW'(cnak) << B_NAKEFF);
  end

  always_ff @(posedge clk) begin
    if (rst) sticky_q <= '0;
    else     sticky_q <= ((sticky_q & ~clr_v) | set_v) & STICKY;
  end

  assign empty_cond = HAS_FIFO && (full_only ? (fill == '0) : (fill <= HALF));

  always_ff @(posedge clk) begin
    if (rst) empty_q <= HAS_FIFO;
    else     empty_q <= empty_cond;
  end

  assign flags = sticky_q | ((EPW'(empty_q) << B_TXFE) & VALID);

  // a bit neither strobed nor cleared keeps its value
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ((evt == '0) && (clr == '0) && !cnak) |=> ((flags & STICKY) == $past(flags & STICKY)));

  // a qualified strobe always lands, even against a clear
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (set_v != '0) |=> ((flags & $past(set_v)) == $past(set_v)));

  assert_buserr_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (!flags[B_BUSERR] && !dma_en) |=> !flags[B_BUSERR]);

  assert_timeout_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (!flags[B_TIMEOUT] && sg_en) |=> !flags[B_TIMEOUT]);

  assert_empty_level_R5: assert property (@(posedge clk) disable iff (rst)
    (HAS_FIFO && (fill == '0)) |=> flags[B_TXFE]);

  assert_cnak_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (cnak && !evt[B_NAKEFF]) |=> !flags[B_NAKEFF]);
endmodule

// File: rtl/usbep_summary.sv
module usbep_summary
  import usbep_pkg::*;
#(
  parameter int NUM_IN_EP  = 4,
  parameter int NUM_OUT_EP = 4
) (
  input  logic [NUM_IN_EP*EPW-1:0]  in_flags,
  input  logic [NUM_OUT_EP*EPW-1:0] out_flags,
  input  logic [EPW-1:0]            in_mask,
  input  logic [EPW-1:0]            out_mask,
  output logic [REG_DW-1:0]         summary,
  output logic                      in_irq,
  output logic                      out_irq
);
  logic [15:0] in_bits, out_bits;

  for (genvar n = 0; n < 16; n++) begin : g_in
    if (n < NUM_IN_EP) begin : g_act
      assign in_bits[n] = |(in_flags[n*EPW +: EPW] & in_mask);
    end else begin : g_none
      assign in_bits[n] = 1'b0;
    end
  end

  for (genvar n = 0; n < 16; n++) begin : g_out
    if (n < NUM_OUT_EP) begin : g_act
      assign out_bits[n] = |(out_flags[n*EPW +: EPW] & out_mask);
    end else begin : g_none
      assign out_bits[n] = 1'b0;
    end
  end

  assign summary = {out_bits, in_bits};
  assign in_irq  = |in_bits;
  assign out_irq = |out_bits;
endmodule

// File: rtl/usbep_regport.sv
module usbep_regport
  import usbep_pkg::*;
#(
  parameter int NUM_IN_EP  = 4,
  parameter int NUM_OUT_EP = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [REG_AW-1:0]         reg_addr,
  input  logic                      reg_wr,
  input  logic [REG_DW-1:0]         reg_wdata,
  input  logic                      reg_rd,
  output logic [REG_DW-1:0]         reg_rdata,
  input  logic [NUM_IN_EP*EPW-1:0]  in_flags,
  input  logic [NUM_OUT_EP*EPW-1:0] out_flags,
  input  logic [REG_DW-1:0]         summary,
  input  logic                      in_irq,
  input  logic                      out_irq,
  output logic [EPW-1:0]            in_mask,
  output logic [EPW-1:0]            out_mask,
  output logic [NUM_IN_EP*EPW-1:0]  in_clr,
  output logic [NUM_OUT_EP*EPW-1:0] out_clr
);
  localparam logic [EPW-1:0] IN_MSK_OK  = IN_VALID & ~NO_MASK;
  localparam logic [EPW-1:0] OUT_MSK_OK = OUT_VALID & ~NO_MASK;

  logic [1:0]        rgn;
  logic [3:0]        idx;
  logic [REG_DW-1:0] rd_mux;
  logic              wdata_hi_unused;

  assign rgn             = reg_addr[5:4];
  assign idx             = reg_addr[3:0];
  assign wdata_hi_unused = ^reg_wdata[REG_DW-1:EPW];

  for (genvar n = 0; n < NUM_IN_EP; n++) begin : g_inclr
    assign in_clr[n*EPW +: EPW] =
      (reg_wr && rgn == RGN_IN && idx == 4'(n)) ? reg_wdata[EPW-1:0] : '0;
  end

  for (genvar n = 0; n < NUM_OUT_EP; n++) begin : g_outclr
    assign out_clr[n*EPW +: EPW] =
      (reg_wr && rgn == RGN_OUT && idx == 4'(n)) ? reg_wdata[EPW-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_mask  <= '0;
      out_mask <= '0;
    end else if (reg_wr && rgn == RGN_CTRL) begin
      if (idx == A_INMSK)  in_mask  <= reg_wdata[EPW-1:0] & IN_MSK_OK;
      if (idx == A_OUTMSK) out_mask <= reg_wdata[EPW-1:0] & OUT_MSK_OK;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rgn)
      RGN_CTRL: begin
        case (idx)
          A_SUMMARY: rd_mux = summary;
          A_GLOBAL:  rd_mux = {30'b0, out_irq, in_irq};
          A_INMSK:   rd_mux = {16'b0, in_mask};
          A_OUTMSK:  rd_mux = {16'b0, out_mask};
          default:   rd_mux = '0;
        endcase
      end
      RGN_IN: begin
        for (int n = 0; n < NUM_IN_EP; n++)
          if (idx == 4'(n)) rd_mux = {16'b0, in_flags[n*EPW +: EPW]};
      end
      RGN_OUT: begin
        for (int n = 0; n < NUM_OUT_EP; n++)
          if (idx == 4'(n)) rd_mux = {16'b0, out_flags[n*EPW +: EPW]};
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
    else             reg_rdata <= '0;
  end

  assert_rd_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0));

  assert_mask_drop_R6: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (!in_mask[B_DROP] && !out_mask[B_DROP]));
endmodule

// File: rtl/usbep_irq_agg.sv
module usbep_irq_agg
  import usbep_pkg::*;
#(
  parameter int NUM_IN_EP  = 4,
  parameter int NUM_OUT_EP = 4,
  parameter int FIFO_DEPTH = 16,
  localparam int FILL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [REG_AW-1:0]            reg_addr,
  input  logic                         reg_wr,
  input  logic [REG_DW-1:0]            reg_wdata,
  input  logic                         reg_rd,
  output logic [REG_DW-1:0]            reg_rdata,
  input  logic [NUM_IN_EP*EPW-1:0]     in_evt,
  input  logic [NUM_OUT_EP*EPW-1:0]    out_evt,
  input  logic [NUM_IN_EP-1:0]         in_cnak,
  input  logic                         dma_en,
  input  logic                         sg_en,
  input  logic                         txe_full_only,
  input  logic [NUM_IN_EP*FILL_W-1:0]  in_fifo_fill,
  output logic                         in_ep_irq,
  output logic                         out_ep_irq
);
  logic [NUM_IN_EP*EPW-1:0]  in_flags, in_clr;
  logic [NUM_OUT_EP*EPW-1:0] out_flags, out_clr;
  logic [EPW-1:0]            in_mask, out_mask;
  logic [REG_DW-1:0]         summary;

  for (genvar n = 0; n < NUM_IN_EP; n++) begin : g_in_ep
    usbep_flag_bank #(
      .VALID(IN_VALID), .HAS_FIFO(1'b1),
      .FIFO_DEPTH(FIFO_DEPTH), .FILL_W(FILL_W)
    ) u_bank (
      .clk(clk), .rst(rst),
      .evt(in_evt[n*EPW +: EPW]), .clr(in_clr[n*EPW +: EPW]),
      .cnak(in_cnak[n]), .dma_en(dma_en), .sg_en(sg_en),
      .full_only(txe_full_only), .fill(in_fifo_fill[n*FILL_W +: FILL_W]),
      .flags(in_flags[n*EPW +: EPW])
    );
  end

  for (genvar n = 0; n < NUM_OUT_EP; n++) begin : g_out_ep
    usbep_flag_bank #(
      .VALID(OUT_VALID), .HAS_FIFO(1'b0),
      .FIFO_DEPTH(FIFO_DEPTH), .FILL_W(FILL_W)
    ) u_bank (
      .clk(clk), .rst(rst),
      .evt(out_evt[n*EPW +: EPW]), .clr(out_clr[n*EPW +: EPW]),
      .cnak(1'b0), .dma_en(dma_en), .sg_en(sg_en),
      .full_only(txe_full_only), .fill('0),
      .flags(out_flags[n*EPW +: EPW])
    );
  end

  usbep_summary #(.NUM_IN_EP(NUM_IN_EP), .NUM_OUT_EP(NUM_OUT_EP)) u_sum (
    .in_flags(in_flags), .out_flags(out_flags),
    .in_mask(in_mask), .out_mask(out_mask),
    .summary(summary), .in_irq(in_ep_irq), .out_irq(out_ep_irq)
  );

  usbep_regport #(.NUM_IN_EP(NUM_IN_EP), .NUM_OUT_EP(NUM_OUT_EP)) u_regs (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .in_flags(in_flags), .out_flags(out_flags),
    .summary(summary), .in_irq(in_ep_irq), .out_irq(out_ep_irq),
    .in_mask(in_mask), .out_mask(out_mask),
    .in_clr(in_clr), .out_clr(out_clr)
  );

  assert_out_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
    out_ep_irq |-> ((out_flags & {NUM_OUT_EP{out_mask}}) != '0));

  assert_in_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
    in_ep_irq |-> ((in_flags & {NUM_IN_EP{in_mask}}) != '0));
endmodule

// File: tb/usbep_irq_agg_test.sv
module usbep_irq_agg_test;
  localparam int NI = 4, NO = 4, DEPTH = 16;
  localparam int FW = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [5:0]        reg_addr = '0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NI*16-1:0]  in_evt = '0;
  logic [NO*16-1:0]  out_evt = '0;
  logic [NI-1:0]     in_cnak = '0;
  logic              dma_en = 1'b0, sg_en = 1'b0, txe_full_only = 1'b0;
  logic [NI*FW-1:0]  in_fifo_fill = '0;
  logic              in_ep_irq, out_ep_irq;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  usbep_irq_agg #(.NUM_IN_EP(NI), .NUM_OUT_EP(NO), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .in_evt(in_evt), .out_evt(out_evt), .in_cnak(in_cnak),
    .dma_en(dma_en), .sg_en(sg_en), .txe_full_only(txe_full_only),
    .in_fifo_fill(in_fifo_fill), .in_ep_irq(in_ep_irq), .out_ep_irq(out_ep_irq)
  );

  typedef struct packed {
    logic        is_out;
    logic [3:0]  ep;
    logic        dma;
    logic        sg;
    logic [15:0] evt;
    logic [15:0] exp;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'd0, 1'b0, 1'b0, 16'h0001, 16'h0001},  // R2 single event
    '{1'b0, 4'd1, 1'b1, 1'b0, 16'h7FFF, 16'h797F},  // R9 R10 dma on, sg off
    '{1'b0, 4'd2, 1'b0, 1'b1, 16'h7FFF, 16'h7B73},  // R9 R10 dma off, sg on
    '{1'b0, 4'd3, 1'b0, 1'b0, 16'h8480, 16'h0000},  // R4 reserved and level bit
    '{1'b1, 4'd0, 1'b1, 1'b1, 16'h7FFF, 16'h7A07},  // R13 all OUT bits
    '{1'b1, 4'd1, 1'b0, 1'b0, 16'h7FFF, 16'h7803},  // R13 R9 R10 gated
    '{1'b1, 4'd2, 1'b0, 1'b0, 16'h00F8, 16'h0000},  // R13 unimplemented bits
    '{1'b0, 4'd0, 1'b0, 1'b0, 16'h0208, 16'h0008}   // R10 timeout kept, bna dropped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_in(input int ep, input logic [15:0] bits);
    @(negedge clk);
    in_evt[ep*16 +: 16] = bits;
    @(negedge clk);
    in_evt = '0;
  endtask

  task automatic pulse_out(input int ep, input logic [15:0] bits);
    @(negedge clk);
    out_evt[ep*16 +: 16] = bits;
    @(negedge clk);
    out_evt = '0;
  endtask

  task automatic set_fill(input int ep, input int v);
    @(negedge clk);
    in_fifo_fill[ep*FW +: FW] = FW'(v);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(6'h10, d); check("R1 IN word", d, 32'h0000_0080);
    rd(6'h20, d); check("R1 OUT word", d, 32'h0);
    rd(6'h02, d); check("R1 IN mask", d, 32'h0);
    rd(6'h00, d); check("R1 summary", d, 32'h0);
    check("R1 irq lines", {30'b0, out_ep_irq, in_ep_irq}, 32'h0);

    for (int e = 0; e < NI; e++) set_fill(e, DEPTH);
    rd(6'h10, d); check("R5 full fifo", d, 32'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      logic [5:0] a;
      v = VECS[i];
      a = {v.is_out ? 2'd2 : 2'd1, v.ep};
      @(negedge clk);
      dma_en = v.dma; sg_en = v.sg;
      if (v.is_out) pulse_out(int'(v.ep), v.evt);
      else          pulse_in(int'(v.ep), v.evt);
      rd(a, d);
      check($sformatf("R2/R4/R9/R10/R13 vector %0d", i), d, {16'b0, v.exp});
      wr(a, 32'hFFFF_FFFF);
      rd(a, d);
      check($sformatf("R2 cleared vector %0d", i), d, 32'h0);
    end
    @(negedge clk);
    dma_en = 1'b0; sg_en = 1'b0;

    // R2 sticky, write of 0 ignored
    pulse_in(1, 16'h0001);
    repeat (3) @(negedge clk);
    wr(6'h11, 32'h0);
    rd(6'h11, d); check("R2 sticky after write 0", d, 32'h1);
    wr(6'h11, 32'h1);
    rd(6'h11, d); check("R2 cleared by write 1", d, 32'h0);

    // R3 set beats clear
    @(negedge clk);
    in_evt[1*16 +: 16] = 16'h0002;
    reg_addr = 6'h11; reg_wdata = 32'h2; reg_wr = 1'b1;
    @(negedge clk);
    in_evt = '0; reg_wr = 1'b0;
    rd(6'h11, d); check("R3 set wins", d, 32'h2);
    wr(6'h11, 32'h2);

    // R11 clear-NAK
    pulse_in(2, 16'h0040);
    rd(6'h12, d); check("R11 nak effective set", d, 32'h40);
    @(negedge clk); in_cnak[2] = 1'b1;
    @(negedge clk); in_cnak = '0;
    rd(6'h12, d); check("R11 cnak clears", d, 32'h0);
    @(negedge clk); in_cnak[2] = 1'b1; in_evt[2*16 +: 16] = 16'h0040;
    @(negedge clk); in_cnak = '0; in_evt = '0;
    rd(6'h12, d); check("R11 strobe beats cnak", d, 32'h40);
    wr(6'h12, 32'h40);

    // R5 empty threshold modes
    set_fill(0, DEPTH / 2);
    rd(6'h10, d); check("R5 half mode at half", d, 32'h80);
    set_fill(0, DEPTH / 2 + 1);
    rd(6'h10, d); check("R5 half mode above half", d, 32'h0);
    set_fill(0, DEPTH / 2);
    @(negedge clk); txe_full_only = 1'b1;
    rd(6'h10, d); check("R5 full-only mode at half", d, 32'h0);
    set_fill(0, 0);
    rd(6'h10, d); check("R5 full-only mode empty", d, 32'h80);
    wr(6'h10, 32'h80);
    rd(6'h10, d); check("R5 write ignored on level bit", d, 32'h80);
    set_fill(0, DEPTH);
    @(negedge clk); txe_full_only = 1'b0;
    rd(6'h10, d); check("R5 back to full", d, 32'h0);

    // R6 packet dropped never interrupts
    wr(6'h02, 32'hFFFF_FFFF);
    rd(6'h02, d); check("R6 IN mask bits", d, 32'h73FF);
    wr(6'h03, 32'hFFFF_FFFF);
    rd(6'h03, d); check("R6 OUT mask bits", d, 32'h7207);
    pulse_out(3, 16'h0800);
    rd(6'h23, d); check("R6 drop flag visible", d, 32'h800);
    check("R6 no OUT irq", {31'b0, out_ep_irq}, 32'h0);
    rd(6'h00, d); check("R6 summary clear", d, 32'h0);

    // R7 / R8 summary and global lines
    pulse_in(2, 16'h0001);
    check("R8 IN irq rises", {31'b0, in_ep_irq}, 32'h1);
    rd(6'h00, d); check("R7 summary IN bit", d, 32'h0000_0004);
    pulse_out(1, 16'h1000);
    check("R8 OUT irq rises", {31'b0, out_ep_irq}, 32'h1);
    rd(6'h00, d); check("R7 summary both halves", d, 32'h0002_0004);
    rd(6'h01, d); check("R8 global register", d, 32'h3);
    wr(6'h02, 32'h73FE);
    check("R7 mask drops IN irq", {31'b0, in_ep_irq}, 32'h0);
    rd(6'h12, d); check("R7 flag kept under mask", d, 32'h1);
    wr(6'h21, 32'h1000);
    check("R8 clear drops OUT irq", {31'b0, out_ep_irq}, 32'h0);
    rd(6'h01, d); check("R8 global cleared", d, 32'h0);

    // R5 with R7: level flag enabled raises the line
    set_fill(3, 0);
    @(negedge clk);
    check("R5 level raises IN irq", {31'b0, in_ep_irq}, 32'h1);
    rd(6'h00, d); check("R7 summary from level bit", d, 32'h0000_0008);

    // R12 unmapped reads and idle data
    rd(6'h3F, d); check("R12 unmapped", d, 32'h0);
    rd(6'h1A, d); check("R12 missing endpoint", d, 32'h0);
    rd(6'h12, d); check("R12 read data", d, 32'h1);
    @(negedge clk);
    check("R12 idle data zero", reg_rdata, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule